// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog for a small microcontroller. Once software starts it, an 8-bit tick counter advances on a divided clock. If software does not restart the count before the counter passes 256 ticks, the block raises a one-cycle reset request for the chip's reset generator. A power-of-two prescaler derives the tick from the system clock. A 3-bit period code selects the divider, so the eight overflow periods span a factor of 128.

A single byte-wide write port reaches two registers. The guard register only takes part in an unlock handshake and holds nothing software can read. The control register holds the start bit, the restart bit and the period code. It accepts a write only right after the two-byte unlock sequence has arrived on the guard register, and each unlock covers a single control write. A control write made while locked is dropped and raises a sticky error flag. A fuse input, driven from non-volatile configuration, must also be high for the counter to move. Software cannot stop the watchdog once it is started. Only the external reset or the watchdog's own bite clears it, and the bite returns the whole block to its reset state.

Top module: `kwdt_top`

## Requirements
- R1: After the synchronous active-high `rst`, `ctrl_rd` is 00h, `wd_count` is 0, `lock_err` is 0 and `wd_bite` is 0.
- R2: A guard write (`wr_reg`=1) of 1Eh followed directly by a guard write of E1h unlocks exactly one control write (`wr_reg`=0). A second control write after that is ignored.
- R3: A guard write whose value breaks the 1Eh, E1h order returns the lock to its idle state. A control write between the two key bytes also returns it to idle. A control write made while locked leaves the control register unchanged and sets `lock_err`, which stays set until a reset.
- R4: Control layout: bit 7 starts the watchdog, bit 5 restarts the count, and bits 2:0 are the period code. `ctrl_rd` shows bit 7 and bits 2:0, with bit 5 and bits 6, 4, 3 always reading 0.
- R5: Once bit 7 of the control register is 1, a control write with bit 7 at 0 leaves it at 1.
- R6: While `fuse_en` is 0, `wd_count` does not advance, even with bit 7 set.
- R7: While running, `wd_count` advances by one every 2^(BASE+code) clock cycles. The first advance comes that many cycles after the edge that accepted the start write.
- R8: When the counter passes 255 ticks, `wd_bite` is high for exactly one cycle, 256·2^(BASE+code) cycles after the starting edge.
- R9: The bite edge clears the control register, the counter, the prescaler, the unlock state and `lock_err`.
- R10: An accepted control write with bit 5 set zeroes both the counter and the prescaler. If the overflow would happen on that same edge, the restart wins and no bite is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high external reset |
| fuse_en | input | 1 | Non-volatile enable; 0 freezes the watchdog |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_reg | input | 1 | Target register: 0 control, 1 guard |
| wr_data | input | 8 | Write data |
| ctrl_rd | output | 8 | Control register read-back |
| wd_count | output | CNT_W | Current tick count |
| lock_err | output | 1 | Sticky flag for a control write made while locked |
| wd_bite | output | 1 | One-cycle system reset request |

## Verification
Register effects appear one edge after the write strobe, so the bench drives every write on a falling edge and reads back on the following falling edge. Counting from the edge that accepts the start write, with divider D the counter must read k/D after k edges and the bite must appear after exactly 256·D edges. The period sweep checks the counter and `wd_bite` at every falling edge over the whole window, for each of the eight codes. The restart-versus-overflow race is set up by timing the unlock and restart writes so the restart lands on edge 256 of the fastest period.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int SEL_W   = 3;
    localparam int DATA_W  = 8;
    localparam int RUN_BIT = 7;
    localparam int RST_BIT = 5;

    localparam logic [DATA_W-1:0] KEY_OPEN_A = 8'h1E;
    localparam logic [DATA_W-1:0] KEY_OPEN_B = 8'hE1;

    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,
        LK_HALF = 2'd1,
        LK_OPEN = 2'd2
    } lock_state_e;

    typedef struct packed {
        logic             run;
        logic [SEL_W-1:0] code;
    } wd_ctrl_t;

    function automatic logic [DATA_W-1:0] ctrl_image(wd_ctrl_t c);
        logic [DATA_W-1:0] img;
        img               = '0;
        img[RUN_BIT]      = c.run;
        img[SEL_W-1:0]    = c.code;
        return img;
    endfunction

    function automatic lock_state_e lock_step(lock_state_e cur, logic [DATA_W-1:0] key);
        lock_state_e nxt;
        nxt = LK_IDLE;
        case (cur)
            LK_IDLE: if (key == KEY_OPEN_A) nxt = LK_HALF;
            LK_HALF: if (key == KEY_OPEN_B) nxt = LK_OPEN;
            default: nxt = LK_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/kwdt_keylock.sv
module kwdt_keylock
    import kwdt_pkg::*;
(
    input  logic              clk,
    input  logic              srst,
    input  logic              key_wr,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] key_data,
    output logic              unlocked
);

    lock_state_e state_q;
    lock_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (key_wr) begin
            state_d = lock_step(state_q, key_data);
        end else if (ctrl_wr) begin
            state_d = LK_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            state_q <= LK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign unlocked = (state_q == LK_OPEN);

endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler
    import kwdt_pkg::*;
#(
    parameter int BASE = 4
) (
    input  logic             clk,
    input  logic             srst,
    input  logic             run,
    input  logic             clr,
    input  logic [SEL_W-1:0] code,
    output logic             tick
);

    localparam int SPAN = BASE + (1 << SEL_W) - 1;
    localparam int PW   = (SPAN > 0) ? SPAN : 1;

    logic [PW-1:0] pre_q;
    logic [PW:0]   limit;

    always_comb begin
        limit = ((PW+1)'(1) << (BASE + int'(code))) - (PW+1)'(1);
    end

    assign tick = run && ({1'b0, pre_q} >= limit);

    always_ff @(posedge clk) begin
        if (srst || clr) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             srst,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);

    logic [CNT_W-1:0] cnt_q;

    assign ovf   = tick && (cnt_q == {CNT_W{1'b1}});
    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (srst || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int BASE  = 4,
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fuse_en,
    input  logic              wr_en,
    input  logic              wr_reg,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] ctrl_rd,
    output logic [CNT_W-1:0]  wd_count,
    output logic              lock_err,
    output logic              wd_bite
);

    wd_ctrl_t ctrl_q;
    logic     err_q;
    logic     bite_q;
    logic     ctrl_wr;
    logic     key_wr;
    logic     unlocked;
    logic     accept;
    logic     restart;
    logic     running;
    logic     tick;
    logic     ovf;
    logic     wd_fire;
    logic     srst;

    assign ctrl_wr = wr_en && (wr_reg == 1'b0);
    assign key_wr  = wr_en && (wr_reg == 1'b1);
    assign accept  = ctrl_wr && unlocked;
    assign restart = accept && wr_data[RST_BIT];
    assign running = ctrl_q.run && fuse_en;
    assign wd_fire = ovf && !restart;
    assign srst    = rst || wd_fire;

    kwdt_keylock u_lock (
        .clk      (clk),
        .srst     (srst),
        .key_wr   (key_wr),
        .ctrl_wr  (ctrl_wr),
        .key_data (wr_data),
        .unlocked (unlocked)
    );

    kwdt_prescaler #(.BASE(BASE)) u_pre (
        .clk  (clk),
        .srst (srst),
        .run  (running),
        .clr  (restart),
        .code (ctrl_q.code),
        .tick (tick)
    );

    kwdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .srst  (srst),
        .clr   (restart),
        .tick  (tick),
        .count (wd_count),
        .ovf   (ovf)
    );

    always_ff @(posedge clk) begin
        if (srst) begin
            ctrl_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (accept) begin
                ctrl_q.run  <= ctrl_q.run | wr_data[RUN_BIT];
                ctrl_q.code <= wr_data[SEL_W-1:0];
            end
            if (ctrl_wr && !unlocked) begin
                err_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bite_q <= 1'b0;
        end else begin
            bite_q <= wd_fire;
        end
    end

    assign ctrl_rd  = ctrl_image(ctrl_q);
    assign lock_err = err_q;
    assign wd_bite  = bite_q;

endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             fuse_en,
    input logic             wr_en,
    input logic [7:0]       ctrl_rd,
    input logic [CNT_W-1:0] wd_count,
    input logic             lock_err,
    input logic             wd_bite
);

    assert_bite_single_R8: assert property (@(posedge clk) disable iff (rst)
        wd_bite |=> !wd_bite);

    assert_bite_clears_R9: assert property (@(posedge clk) disable iff (rst)
        wd_bite |-> (wd_count == '0) && (ctrl_rd == 8'h00) && !lock_err);

    assert_run_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_rd[7]) |-> wd_bite);

    assert_err_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_err) |-> wd_bite);

    assert_fuse_freeze_R6: assert property (@(posedge clk) disable iff (rst)
        (!fuse_en && !wr_en) |=> $stable(wd_count));

    assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(wd_count) |-> ((wd_count == $past(wd_count) + 1'b1) || (wd_count == '0)));

    always @(posedge clk) begin
        if (!rst) begin
            assert_reserved_zero_R4: assert (ctrl_rd[6:3] == 4'b0000 && ctrl_rd[5] == 1'b0);
        end
    end

endmodule

bind kwdt_top kwdt_checker #(.CNT_W(CNT_W)) u_kwdt_checker (
    .clk      (clk),
    .rst      (rst),
    .fuse_en  (fuse_en),
    .wr_en    (wr_en),
    .ctrl_rd  (ctrl_rd),
    .wd_count (wd_count),
    .lock_err (lock_err),
    .wd_bite  (wd_bite)
);

// File: tb/test_kwdt_top.sv
module test_kwdt_top;

    localparam int BASE  = 0;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             fuse_en = 1'b1;
    logic             wr_en = 1'b0;
    logic             wr_reg = 1'b0;
    logic [7:0]       wr_data = 8'h00;
    logic [7:0]       ctrl_rd;
    logic [CNT_W-1:0] wd_count;
    logic             lock_err;
    logic             wd_bite;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    kwdt_top #(.BASE(BASE), .CNT_W(CNT_W)) i_kwdt_top (
        .clk      (clk),
        .rst      (rst),
        .fuse_en  (fuse_en),
        .wr_en    (wr_en),
        .wr_reg   (wr_reg),
        .wr_data  (wr_data),
        .ctrl_rd  (ctrl_rd),
        .wd_count (wd_count),
        .lock_err (lock_err),
        .wd_bite  (wd_bite)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        check(act == exp, tag, act, exp);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put(input bit which, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_reg  = which;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic open_lock();
        put(1'b1, 8'h1E);
        put(1'b1, 8'hE1);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wait_n(3);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk_eq("R1 ctrl", ctrl_rd, 8'h00);
        chk_eq("R1 count", wd_count, 0);
        chk_eq("R1 err", lock_err, 0);
        chk_eq("R1 bite", wd_bite, 0);

        // R3 locked write ignored, flag set
        put(1'b0, 8'h87);
        chk_eq("R3 locked ctrl", ctrl_rd, 8'h00);
        chk_eq("R3 err set", lock_err, 1);
        // R3 broken sequence
        put(1'b1, 8'h1E); put(1'b1, 8'h55); put(1'b1, 8'hE1); put(1'b0, 8'h83);
        chk_eq("R3 broken seq", ctrl_rd, 8'h00);
        put(1'b1, 8'hE1); put(1'b1, 8'h1E); put(1'b0, 8'h83);
        chk_eq("R3 reversed seq", ctrl_rd, 8'h00);
        put(1'b1, 8'h1E); put(1'b0, 8'h83); put(1'b1, 8'hE1); put(1'b0, 8'h83);
        chk_eq("R3 interleaved write", ctrl_rd, 8'h00);
        chk_eq("R3 err sticky", lock_err, 1);

        // R2 one unlock per write
        do_reset();
        open_lock();
        put(1'b0, 8'h03);
        chk_eq("R2 accepted", ctrl_rd, 8'h03);
        chk_eq("R2 no err", lock_err, 0);
        put(1'b0, 8'h05);
        chk_eq("R2 second write ignored", ctrl_rd, 8'h03);
        chk_eq("R2 err after consume", lock_err, 1);

        // R4 read-back, R6 fuse gate, R5 sticky run, R7 first tick
        do_reset();
        fuse_en = 1'b0;
        open_lock();
        put(1'b0, 8'hFF);
        chk_eq("R4 readback", ctrl_rd, 8'h87);
        wait_n(50);
        chk_eq("R6 frozen", wd_count, 0);
        open_lock();
        put(1'b0, 8'h07);
        chk_eq("R5 run kept", ctrl_rd, 8'h87);
        fuse_en = 1'b1;
        wait_n(127);
        chk_eq("R7 before tick", wd_count, 0);
        wait_n(1);
        chk_eq("R7 first tick", wd_count, 1);

        // R10 restart zeroes prescaler and counter (code 2, D=4)
        do_reset();
        open_lock();
        put(1'b0, 8'h82);
        wait_n(4);
        chk_eq("R7 code2 tick", wd_count, 1);
        open_lock();
        put(1'b0, 8'hA2);
        chk_eq("R10 count zero", wd_count, 0);
        wait_n(3);
        chk_eq("R10 prescaler zero", wd_count, 0);
        wait_n(1);
        chk_eq("R10 tick after restart", wd_count, 1);

        // R10 restart beats overflow on the same edge (code 0)
        do_reset();
        open_lock();
        put(1'b0, 8'h80);
        wait_n(253);
        chk_eq("R10 pre race count", wd_count, 253);
        open_lock();
        chk_eq("R10 at 255", wd_count, 255);
        put(1'b0, 8'hA0);
        chk_eq("R10 race no bite", wd_bite, 0);
        chk_eq("R10 race count", wd_count, 0);
        chk_eq("R10 race ctrl", ctrl_rd, 8'h80);
        wait_n(1);
        chk_eq("R10 race bite later", wd_bite, 0);

        // R9 bite clears lock state and error flag
        do_reset();
        put(1'b0, 8'h00);
        open_lock();
        put(1'b0, 8'h80);
        open_lock();
        wait_n(253);
        chk_eq("R9 before bite", wd_bite, 0);
        wait_n(1);
        chk_eq("R9 bite", wd_bite, 1);
        chk_eq("R9 err cleared", lock_err, 0);
        chk_eq("R9 ctrl cleared", ctrl_rd, 8'h00);
        put(1'b0, 8'h81);
        chk_eq("R9 lock reset", ctrl_rd, 8'h00);
        chk_eq("R9 err again", lock_err, 1);

        // R7 R8 sweep over all period codes
        for (int code = 0; code < 8; code++) begin
            int d;
            int total;
            int bad;
            d     = 1 << (BASE + code);
            total = 256 * d;
            bad   = 0;
            do_reset();
            open_lock();
            put(1'b0, 8'h80 | 8'(code));
            chk_eq("R4 sweep ctrl", ctrl_rd, 8'h80 | code);
            for (int k = 1; k <= total; k++) begin
                int ec;
                int eb;
                @(negedge clk);
                ec = (k / d) % 256;
                eb = (k == total) ? 1 : 0;
                if (wd_count != ec[CNT_W-1:0]) begin
                    check(1'b0, "R7 sweep count", wd_count, ec);
                    bad++;
                end
                if (wd_bite != eb[0]) begin
                    check(1'b0, "R8 sweep bite", wd_bite, eb);
                    bad++;
                end
                if (bad > 4) break;
            end
            check(bad == 0, "R7 sweep window", bad, 0);
            chk_eq("R9 sweep ctrl", ctrl_rd, 8'h00);
            wait_n(1);
            chk_eq("R8 pulse width", wd_bite, 0);
            chk_eq("R9 stays idle", wd_count, 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule